// File: doc/BRIEF.md
# Device-Paced Ready Wait Controller

This block runs the data phase of an access on an external peripheral bus where the device slows the access down through a ready input. A start pulse launches an access of one or more beats. Per-bank settings are captured at start. They choose whether ready is watched at all and how many cycles pass before the first ready sample. That count is taken from a single-access value on a non-burst bank, and from a first-beat or later-beat value on a burst bank. A mode bit chooses whether data moves at the edge where ready is seen high or one cycle later.

Each beat ends with a one-cycle transfer strobe followed by a programmable number of hold cycles. A global setting either lets the controller wait for ready without limit, or bounds the wait. When the wait is bounded and the device stays silent too long, the access is abandoned with an error pulse. The bound applies to each beat on its own, and any change of the peripheral address starts the count again. A bank set up with ready enabled and a nonzero byte-enable-off value is refused with a configuration error.

Top module: `rdy_wait_ctrl`

## Requirements
- R1: After reset, xfer_stb, hold_phase, done, err_pulse, cfg_err and busy are all low.
- R2: With the bank's ready-enable clear, the ready input is ignored. With a wait count W, the strobe is high in cycle W+1 after the start edge, where cycle k is the one following the k-th clock edge after the edge that samples start.
- R3: The wait count is taken from single_wait on a non-burst bank. On a burst bank it is taken from first_wait for the first beat and from next_wait for each later beat, and a later beat begins its count at the edge that ends the previous beat's hold.
- R4: With ready enabled, ready is sampled once per clock from the edge that ends the wait count, and each low sample adds one cycle before the transfer.
- R5: With the same-edge mode set, the strobe is high in the cycle after the edge that samples ready high. With it clear, the strobe comes one cycle later.
- R6: After each strobe, hold_phase is high for the programmed hold count of cycles. With ready enabled, the same-edge mode set and a hold count of zero, exactly one hold cycle is produced.
- R7: With the timeout-disable input high, the controller never raises err_pulse and waits for ready indefinitely.
- R8: With timeouts enabled and a limit L of at least 1, the L-th low ready sample with an unchanged address aborts the access. err_pulse and done are then high together for one cycle, no strobe is issued, and busy is low afterwards.
- R9: A change of the peripheral address clears the timeout count, so the sample at the edge that sees the new address counts as the first one.
- R10: A burst bank performs burst_len beats, with a length of zero treated as one. A non-burst bank performs one beat. done pulses for one cycle in the cycle after the last beat's final hold cycle, or after its strobe when there is no hold.
- R11: A start with ready-enable set and a nonzero byte_en_off raises cfg_err in the cycle after the start edge. No access begins: no strobe and no done follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches an access when idle |
| burst_len | input | LEN_W | Beats in a burst access |
| bank_burst | input | 1 | Bank uses burst accesses |
| bank_rdy_en | input | 1 | Bank honours the ready input |
| bank_same_edge | input | 1 | Transfer at the edge where ready is seen |
| single_wait | input | WAIT_W | Wait before sampling, non-burst bank |
| first_wait | input | WAIT_W | Wait before sampling, first burst beat |
| next_wait | input | WAIT_W | Wait before sampling, later burst beats |
| hold_cnt | input | HOLD_W | Hold cycles after each strobe |
| byte_en_off | input | HOLD_W | Byte-enable-off setting, must be zero with ready |
| to_disable | input | 1 | Wait for ready without limit |
| to_limit | input | TO_W | Low samples allowed per beat |
| periph_addr | input | ADDR_W | Current peripheral address |
| dev_ready | input | 1 | Ready from the device |
| busy | output | 1 | Access in progress |
| xfer_stb | output | 1 | One-cycle data transfer strobe |
| hold_phase | output | 1 | Hold cycle after a transfer |
| done | output | 1 | Access finished (or aborted) |
| err_pulse | output | 1 | Timeout abort |
| cfg_err | output | 1 | Start refused for a bad setting |

## Verification
A wrong wait or hold counter moves the strobe, the hold cycles or done away from their expected cycle. The bench records the exact cycle index of each and compares it, so such a fault shows within the same access. A timeout counter that fails to restart on an address change raises err_pulse two cycles early, and a dropped restart between beats shows up on the second beat. An error in the beat counter changes the number of strobes and moves done by whole beats.

// File: rtl/rdy_wait_pkg.sv
package rdy_wait_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_LATE,
    ST_HOLD
  } rw_state_t;
endpackage

// File: rtl/rdy_wait_down.sv
module rdy_wait_down #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/rdy_wait_tmo.sv
module rdy_wait_tmo #(
  parameter int TO_W   = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              sample_low,
  input  logic [ADDR_W-1:0] addr,
  input  logic              to_dis,
  input  logic [TO_W-1:0]   limit,
  output logic              expire
);
  logic [TO_W-1:0]   cnt, base;
  logic [ADDR_W-1:0] addr_q;
  logic [TO_W:0]     nxt;

  always_comb begin
    base   = (restart || addr != addr_q) ? '0 : cnt;
    nxt    = {1'b0, base} + 1'b1;
    expire = sample_low && !to_dis && (nxt >= {1'b0, limit});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      addr_q <= '0;
    end else begin
      addr_q <= addr;
      if (restart) cnt <= '0;
      else if (sample_low) cnt <= nxt[TO_W-1:0];
      else cnt <= base;
    end
  end
endmodule

// File: rtl/rdy_wait_ctrl.sv
module rdy_wait_ctrl #(
  parameter int WAIT_W = 4,
  parameter int HOLD_W = 3,
  parameter int TO_W   = 8,
  parameter int LEN_W  = 4,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LEN_W-1:0]  burst_len,
  input  logic              bank_burst,
  input  logic              bank_rdy_en,
  input  logic              bank_same_edge,
  input  logic [WAIT_W-1:0] single_wait,
  input  logic [WAIT_W-1:0] first_wait,
  input  logic [WAIT_W-1:0] next_wait,
  input  logic [HOLD_W-1:0] hold_cnt,
  input  logic [HOLD_W-1:0] byte_en_off,
  input  logic              to_disable,
  input  logic [TO_W-1:0]   to_limit,
  input  logic [ADDR_W-1:0] periph_addr,
  input  logic              dev_ready,
  output logic              busy,
  output logic              xfer_stb,
  output logic              hold_phase,
  output logic              done,
  output logic              err_pulse,
  output logic              cfg_err
);
  import rdy_wait_pkg::*;

  rw_state_t st, st_nxt;

  logic              cfg_rdy, cfg_same;
  logic [WAIT_W-1:0] cfg_next;
  logic [HOLD_W-1:0] cfg_hold, eff_hold;
  logic [LEN_W-1:0]  rem;

  logic go, bad, smp, rdy_hit, low, xfer_now, beat_end, last;
  logic wz, hz, w_load, expire;
  logic [WAIT_W-1:0] w_val;

  always_comb begin
    go       = (st == ST_IDLE) && start && !(bank_rdy_en && byte_en_off != '0);
    bad      = (st == ST_IDLE) && start && bank_rdy_en && byte_en_off != '0;
    smp      = (st == ST_WAIT) && wz;
    rdy_hit  = smp && cfg_rdy && dev_ready;
    low      = smp && cfg_rdy && !dev_ready;
    xfer_now = (smp && !cfg_rdy) || (rdy_hit && cfg_same) || (st == ST_LATE);
    beat_end = (st == ST_HOLD) && hz;
    last     = (rem == '0);
    w_load   = go || (beat_end && !last);
    w_val    = go ? (bank_burst ? first_wait : single_wait) : cfg_next;
    eff_hold = (cfg_same && cfg_rdy && cfg_hold == '0) ? HOLD_W'(1) : cfg_hold;
  end

  rdy_wait_down #(.W(WAIT_W)) u_wait (
    .clk(clk), .rst(rst), .load(w_load), .load_val(w_val),
    .dec(st == ST_WAIT), .zero(wz)
  );

  rdy_wait_down #(.W(HOLD_W)) u_hold (
    .clk(clk), .rst(rst), .load(xfer_now), .load_val(eff_hold),
    .dec(st == ST_HOLD), .zero(hz)
  );

  rdy_wait_tmo #(.TO_W(TO_W), .ADDR_W(ADDR_W)) u_tmo (
    .clk(clk), .rst(rst), .restart(w_load), .sample_low(low),
    .addr(periph_addr), .to_dis(to_disable), .limit(to_limit),
    .expire(expire)
  );

  always_comb begin
    st_nxt = st;
    case (st)
      ST_IDLE: if (go) st_nxt = ST_WAIT;
      ST_WAIT: begin
        if (xfer_now) st_nxt = ST_HOLD;
        else if (rdy_hit) st_nxt = ST_LATE;
        else if (expire) st_nxt = ST_IDLE;
      end
      ST_LATE: st_nxt = ST_HOLD;
      ST_HOLD: if (hz) st_nxt = last ? ST_IDLE : ST_WAIT;
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      busy       <= 1'b0;
      xfer_stb   <= 1'b0;
      hold_phase <= 1'b0;
      done       <= 1'b0;
      err_pulse  <= 1'b0;
      cfg_err    <= 1'b0;
      cfg_rdy    <= 1'b0;
      cfg_same   <= 1'b0;
      cfg_next   <= '0;
      cfg_hold   <= '0;
      rem        <= '0;
    end else begin
      st         <= st_nxt;
      busy       <= (st_nxt != ST_IDLE);
      xfer_stb   <= xfer_now;
      hold_phase <= (st == ST_HOLD) && !hz;
      cfg_err    <= bad;
      err_pulse  <= (st == ST_WAIT) && !xfer_now && !rdy_hit && expire;
      done       <= ((st == ST_WAIT) && !xfer_now && !rdy_hit && expire) ||
                    (beat_end && last);
      if (go) begin
        cfg_rdy  <= bank_rdy_en;
        cfg_same <= bank_same_edge;
        cfg_next <= next_wait;
        cfg_hold <= hold_cnt;
        rem      <= (bank_burst && burst_len != '0) ? burst_len - 1'b1 : '0;
      end else if (beat_end && !last) begin
        rem <= rem - 1'b1;
      end
    end
  end
endmodule

// File: rtl/rdy_wait_ctrl_chk.sv
module rdy_wait_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic to_disable,
  input logic busy,
  input logic xfer_stb,
  input logic hold_phase,
  input logic done,
  input logic err_pulse,
  input logic cfg_err
);
  assert_err_with_done_R8: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> done);
  assert_err_no_stb_R8: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> !xfer_stb);
  assert_no_err_when_unbounded_R7: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> !$past(to_disable));
  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_stb_while_busy_R10: assert property (@(posedge clk) disable iff (rst)
    xfer_stb |-> busy);
  assert_hold_not_stb_R6: assert property (@(posedge clk) disable iff (rst)
    hold_phase |-> !xfer_stb);
  assert_cfg_err_idle_R11: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> (!busy && !done));
endmodule

bind rdy_wait_ctrl rdy_wait_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .to_disable(to_disable), .busy(busy),
  .xfer_stb(xfer_stb), .hold_phase(hold_phase), .done(done),
  .err_pulse(err_pulse), .cfg_err(cfg_err)
);

// File: tb/rdy_wait_ctrl_bench.sv
module rdy_wait_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  burst_len = '0;
  logic        bank_burst = 1'b0, bank_rdy_en = 1'b0, bank_same_edge = 1'b0;
  logic [3:0]  single_wait = '0, first_wait = '0, next_wait = '0;
  logic [2:0]  hold_cnt = '0, byte_en_off = '0;
  logic        to_disable = 1'b1;
  logic [7:0]  to_limit = 8'd4;
  logic [15:0] periph_addr = 16'h0100;
  logic        dev_ready = 1'b0;
  logic        busy, xfer_stb, hold_phase, done, err_pulse, cfg_err;

  int n_chk = 0, n_bad = 0;
  int n_x, first_x, last_x, n_h, first_h, done_at, err_at, cerr_at, busy1;
  bit finished = 0;

  always #5 clk = ~clk;

  rdy_wait_ctrl u_rdy_wait_ctrl (
    .clk(clk), .rst(rst), .start(start), .burst_len(burst_len),
    .bank_burst(bank_burst), .bank_rdy_en(bank_rdy_en),
    .bank_same_edge(bank_same_edge), .single_wait(single_wait),
    .first_wait(first_wait), .next_wait(next_wait), .hold_cnt(hold_cnt),
    .byte_en_off(byte_en_off), .to_disable(to_disable), .to_limit(to_limit),
    .periph_addr(periph_addr), .dev_ready(dev_ready), .busy(busy),
    .xfer_stb(xfer_stb), .hold_phase(hold_phase), .done(done),
    .err_pulse(err_pulse), .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Pulse start, then record outputs for cycles 0..ncyc (cycle k follows edge k after the start edge)
  task automatic run(input int ncyc, input int rdy_rise, input int addr_at);
    n_x = 0; first_x = -1; last_x = -1; n_h = 0; first_h = -1;
    done_at = -1; err_at = -1; cerr_at = -1; busy1 = -1;
    @(negedge clk); start = 1'b1;
    for (int k = 0; k <= ncyc; k++) begin
      @(negedge clk);
      if (k == 0) start = 1'b0;
      if (xfer_stb) begin n_x++; if (first_x < 0) first_x = k; last_x = k; end
      if (hold_phase) begin n_h++; if (first_h < 0) first_h = k; end
      if (done && done_at < 0) done_at = k;
      if (err_pulse && err_at < 0) err_at = k;
      if (cfg_err && cerr_at < 0) cerr_at = k;
      if (k == 1) busy1 = busy;
      if (k == rdy_rise) dev_ready = 1'b1;
      if (k == addr_at) periph_addr = periph_addr + 16'h4;
    end
  endtask

  task automatic set_bank(input bit burst, input bit rdy, input bit same,
                          input int sw, input int fw, input int nw, input int h);
    bank_burst = burst; bank_rdy_en = rdy; bank_same_edge = same;
    single_wait = 4'(sw); first_wait = 4'(fw); next_wait = 4'(nw);
    hold_cnt = 3'(h); byte_en_off = '0;
  endtask

  task automatic t_reset;
    chk("R1 xfer_stb", xfer_stb, 0); chk("R1 hold_phase", hold_phase, 0);
    chk("R1 done", done, 0); chk("R1 err_pulse", err_pulse, 0);
    chk("R1 cfg_err", cfg_err, 0); chk("R1 busy", busy, 0);
  endtask

  task automatic t_ready_off;
    set_bank(0, 0, 1, 3, 0, 0, 2); dev_ready = 1'b0; to_disable = 1'b0;
    run(12, -1, -1);
    chk("R2 strobe cycle", first_x, 4); chk("R6 hold count", n_h, 2);
    chk("R6 hold first", first_h, 5); chk("R10 done cycle", done_at, 7);
    chk("R2 no error", err_at, -1);
    to_disable = 1'b1;
  endtask

  task automatic t_same_edge;
    set_bank(0, 1, 1, 2, 0, 0, 1); dev_ready = 1'b1;
    run(10, -1, -1);
    chk("R5 same-edge strobe", first_x, 3); chk("R6 hold first", first_h, 4);
    chk("R10 done", done_at, 5); chk("R10 busy", busy1, 1);
  endtask

  task automatic t_next_edge;
    set_bank(0, 1, 0, 2, 0, 0, 1); dev_ready = 1'b1;
    run(10, -1, -1);
    chk("R5 next-edge strobe", first_x, 4); chk("R10 done", done_at, 6);
  endtask

  task automatic t_wait_states;
    set_bank(0, 1, 1, 1, 0, 0, 0); dev_ready = 1'b0;
    run(14, 6, -1);
    chk("R4 strobe after lows", first_x, 7); chk("R6 forced hold", n_h, 1);
    chk("R6 forced hold cycle", first_h, 8); chk("R4 done", done_at, 9);
  endtask

  task automatic t_zero_hold_late;
    set_bank(0, 1, 0, 0, 0, 0, 0); dev_ready = 1'b1;
    run(8, -1, -1);
    chk("R5 late strobe", first_x, 2); chk("R6 no hold", n_h, 0);
    chk("R6 done", done_at, 3);
  endtask

  task automatic t_timeout;
    set_bank(0, 1, 1, 0, 0, 0, 0); dev_ready = 1'b0;
    to_disable = 1'b0; to_limit = 8'd4;
    run(10, -1, -1);
    chk("R8 error cycle", err_at, 4); chk("R8 done with error", done_at, 4);
    chk("R8 no strobe", n_x, 0); chk("R8 idle after", busy, 0);
  endtask

  task automatic t_unbounded;
    set_bank(0, 1, 1, 0, 0, 0, 0); dev_ready = 1'b0;
    to_disable = 1'b1; to_limit = 8'd4;
    run(16, 10, -1);
    chk("R7 no error", err_at, -1); chk("R7 strobe", first_x, 11);
    chk("R7 done", done_at, 13);
  endtask

  task automatic t_addr_restart;
    set_bank(0, 1, 1, 0, 0, 0, 0); dev_ready = 1'b0;
    to_disable = 1'b0; to_limit = 8'd4;
    run(12, -1, 2);
    chk("R9 error delayed", err_at, 6); chk("R9 no strobe", n_x, 0);
    to_disable = 1'b1;
  endtask

  task automatic t_burst;
    set_bank(1, 1, 1, 7, 2, 1, 0); dev_ready = 1'b1; burst_len = 4'd3;
    run(18, -1, -1);
    chk("R10 beats", n_x, 3); chk("R3 first beat", first_x, 3);
    chk("R3 later beat", last_x, 11); chk("R6 holds", n_h, 3);
    chk("R10 done", done_at, 13);
  endtask

  task automatic t_single_bank;
    set_bank(0, 0, 0, 2, 5, 5, 0); dev_ready = 1'b0; burst_len = 4'd3;
    run(12, -1, -1);
    chk("R3 single wait", first_x, 3); chk("R10 one beat", n_x, 1);
    chk("R10 done", done_at, 4);
  endtask

  task automatic t_cfg_err;
    set_bank(0, 1, 1, 0, 0, 0, 0); byte_en_off = 3'd2; dev_ready = 1'b1;
    run(8, -1, -1);
    chk("R11 cfg_err", cerr_at, 0); chk("R11 no strobe", n_x, 0);
    chk("R11 no done", done_at, -1); chk("R11 not busy", busy1, 0);
    byte_en_off = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ready_off();
    t_same_edge();
    t_next_edge();
    t_wait_states();
    t_zero_hold_late();
    t_timeout();
    t_unbounded();
    t_addr_restart();
    t_burst();
    t_single_bank();
    t_cfg_err();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule